// File: doc/BRIEF.md
# Hashed Page-Table Group Search Unit

This unit looks for a translation inside one group of eight page-table entries held in memory. A caller supplies the group's base address, the word an entry must match, the hash selector (primary or secondary), the direction of the access, a protection key, the effective address and the page size. It then pulses `start`. The unit reads the entries in order through a 32-bit request/response memory port. For every entry it fetches the first word. It fetches the second word only when the first word makes the entry a match.

For each match the unit first checks the entry against any earlier match in the same search. It then derives the access rights from the key and the entry's protection field, and it either stops (access granted) or keeps going (protection violation). When the scan is over, the unit sets the referenced flag, and on a granted write also the changed flag. It writes the second word back only if that altered it. It then pulses `done` with a result code, the updated real-address word, the rights and the entry index. Computing the hash, caching translations and raising exceptions are left to the surrounding logic.

Top module: `pteg_search`

## Requirements
- R1: The reads go in ascending entry order. For entry i, the first word is read at base + 8·i. The second word is read at base + 8·i + 4, and only when that entry's first word matched. No read is issued after the scan has ended, and every request address is word aligned.
- R2: An entry matches only when all three hold: bit 31 of its first word is 1, bit 6 of its first word equals `hsel`, and the first word ANDed with 0x7FFFFFBF equals `match_word`.
- R3: Rights come from `key` and the low two bits of the second word (pp). `res_prot` bit 0 means read allowed and bit 1 means write allowed. For key 0: pp 0, 1 or 2 gives 2'b11, and pp 3 gives 2'b01. For key 1: pp 0 gives 2'b00, pp 1 or 3 gives 2'b01, and pp 2 gives 2'b11. An access is granted when the rights bit for its direction is set.
- R4: A granted match ends the scan at once. The result is code 2'b00, the index of that entry, and its rights.
- R5: A protection violation does not end the scan. If no later match grants access, the result is code 2'b01, and the index, word and rights are those of the last match.
- R6: With no match at all, the result is code 2'b10 with `res_raddr`, `res_prot` and `res_index` all zero, and no write is made.
- R7: A second match whose second word differs from the stored one under mask 0xFFFFF07B ends the scan straight after that read. The result is then reported exactly as in R6, with no write.
- R8: Once the scan has ended with a match, bit 8 (0x100) of the second word is set, and on a granted write bit 7 (0x80) is set as well. The updated word is written to base + 8·index + 4 only when it differs from the word that was read. `res_raddr` returns the updated word.
- R9: The effective-address bits from bit 12 up to, but not including, bit `page_log2` are ORed into `res_raddr`. When `page_log2` ≤ 12, no bits are added.
- R10: `busy` rises in the cycle after `start` is accepted and stays high up to and including the single-cycle `done` pulse. A request holds its address, direction and data until `mem_req_ready` is sampled high.
- R11: `start` and all search inputs are ignored while `busy` is high. The running search then keeps its reads, writes and result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (accepted while idle) |
| grp_base | input | 32 | Byte address of the entry group |
| match_word | input | 32 | Value the masked first word must equal |
| hsel | input | 1 | Requested hash selector |
| is_write | input | 1 | 1 for a store access, 0 for a load |
| key | input | 1 | Protection key |
| eff_addr | input | 32 | Effective address of the access |
| page_log2 | input | 5 | log2 of the page size in bytes |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| res_code | output | 2 | 00 granted, 01 violation, 10 not found or inconsistent |
| res_raddr | output | 32 | Updated real-address word with large-page bits |
| res_prot | output | 2 | Rights: bit 0 read, bit 1 write |
| res_index | output | 3 | Index of the reported entry |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 for a write request |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |

## Verification
The timing is fixed by the interface. A request appears in the cycle after `start` is accepted or after the previous read's response arrives. `done` rises on the second clock edge after the final read response when nothing is written back, or on the edge that accepts the write-back. `busy` falls one cycle after `done`. The bench's reference model derives these due cycles from the responses its memory model returns. Once a cycle is due, the model checks `busy`, `done` and the result on every falling edge, and it checks each accepted request against the predicted access sequence. Ready stalls and response latencies are varied, so that a result arriving early or late shows up as a mismatch.

// File: rtl/pteg_pkg.sv
package pteg_pkg;
  localparam int WORD_W = 32;

  // First-word bits compared against the requested match word
  localparam logic [WORD_W-1:0] CMP_MASK   = 32'h7FFF_FFBF;
  // Second-word bits that every match in one group must agree on
  localparam logic [WORD_W-1:0] AGREE_MASK = 32'hFFFF_F07B;
  localparam logic [WORD_W-1:0] REF_FLAG   = 32'h0000_0100;
  localparam logic [WORD_W-1:0] CHG_FLAG   = 32'h0000_0080;
  localparam int SMALL_PAGE_LOG2 = 12;

  typedef enum logic [1:0] {
    RC_GRANT = 2'b00,
    RC_DENY  = 2'b01,
    RC_NONE  = 2'b10
  } rcode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_FIN,
    S_WB_REQ,
    S_DONE
  } st_t;

  // Rights encoding: bit 0 read allowed, bit 1 write allowed
  function automatic logic [1:0] rights(input logic k, input logic [1:0] pp);
    logic [1:0] r;
    case ({k, pp})
      3'b0_00, 3'b0_01, 3'b0_10: r = 2'b11;
      3'b0_11:                   r = 2'b01;
      3'b1_00:                   r = 2'b00;
      3'b1_10:                   r = 2'b11;
      default:                   r = 2'b01;
    endcase
    return r;
  endfunction

  // Effective-address bits between the small-page boundary and the page size
  function automatic logic [WORD_W-1:0] big_page_bits(input logic [WORD_W-1:0] ea,
                                                      input logic [4:0] lg);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int b = SMALL_PAGE_LOG2; b < WORD_W; b++) begin
      if (b < int'(lg)) m[b] = 1'b1;
    end
    return ea & m;
  endfunction

  function automatic logic words_disagree(input logic [WORD_W-1:0] a,
                                          input logic [WORD_W-1:0] b);
    return ((a ^ b) & AGREE_MASK) != '0;
  endfunction
endpackage

// File: rtl/pteg_cand_match.sv
module pteg_cand_match
  import pteg_pkg::*;
(
  input  logic [WORD_W-1:0] first_word,
  input  logic [WORD_W-1:0] want_word,
  input  logic              want_hsel,
  output logic              is_hit
);
  logic valid_bit;
  logic sel_ok;
  logic body_ok;

  always_comb begin
    valid_bit = first_word[WORD_W-1];
    sel_ok    = (first_word[6] == want_hsel);
    body_ok   = ((first_word & CMP_MASK) == want_word);
    is_hit    = valid_bit && sel_ok && body_ok;
  end
endmodule

// File: rtl/pteg_access.sv
module pteg_access
  import pteg_pkg::*;
(
  input  logic       prot_key,
  input  logic [1:0] pp,
  input  logic       is_write,
  output logic [1:0] prot,
  output logic       allow
);
  always_comb begin
    prot  = rights(prot_key, pp);
    allow = is_write ? prot[1] : prot[0];
  end
endmodule

// File: rtl/pteg_flag_merge.sv
module pteg_flag_merge
  import pteg_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  logic              mark_changed,
  output logic [WORD_W-1:0] new_word,
  output logic              differs
);
  always_comb begin
    new_word = old_word | REF_FLAG | (mark_changed ? CHG_FLAG : '0);
    differs  = (new_word != old_word);
  end
endmodule

// File: rtl/pteg_search.sv
module pteg_search
  import pteg_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 32,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     grp_base,
  input  logic [WORD_W-1:0] match_word,
  input  logic              hsel,
  input  logic              is_write,
  input  logic              key,
  input  logic [WORD_W-1:0] eff_addr,
  input  logic [4:0]        page_log2,
  output logic              busy,
  output logic              done,
  output logic [1:0]        res_code,
  output logic [WORD_W-1:0] res_raddr,
  output logic [1:0]        res_prot,
  output logic [IW-1:0]     res_index,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [AW-1:0]     mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  localparam logic [IW-1:0] LAST_IDX = IW'(ENTRIES - 1);

  st_t               st_q;
  logic [IW-1:0]     idx_q;
  logic              half_q;
  logic [AW-1:0]     base_q;
  logic [WORD_W-1:0] mw_q;
  logic              hs_q;
  logic              wr_q;
  logic              key_q;
  logic [WORD_W-1:0] ea_q;
  logic [4:0]        lg_q;
  logic              have_q;
  logic [WORD_W-1:0] saved_q;
  logic [IW-1:0]     good_q;
  logic [1:0]        prot_q;
  rcode_t            code_q;
  logic [WORD_W-1:0] wb_q;

  // Named internal events, observed by the checker
  logic ev_rsp_first;
  logic ev_rsp_second;
  logic ev_clash;
  logic ev_grant;
  logic at_last;

  logic              cand_hit;
  logic [1:0]        acc_prot;
  logic              acc_allow;
  logic [WORD_W-1:0] merged_word;
  logic              merged_differs;

  pteg_cand_match u_match (
    .first_word (mem_rsp_data),
    .want_word  (mw_q),
    .want_hsel  (hs_q),
    .is_hit     (cand_hit)
  );

  pteg_access u_access (
    .prot_key (key_q),
    .pp       (mem_rsp_data[1:0]),
    .is_write (wr_q),
    .prot     (acc_prot),
    .allow    (acc_allow)
  );

  pteg_flag_merge u_merge (
    .old_word     (saved_q),
    .mark_changed (wr_q && (code_q == RC_GRANT)),
    .new_word     (merged_word),
    .differs      (merged_differs)
  );

  always_comb begin
    ev_rsp_first  = (st_q == S_RD_WAIT) && mem_rsp_valid && !half_q;
    ev_rsp_second = (st_q == S_RD_WAIT) && mem_rsp_valid && half_q;
    ev_clash      = ev_rsp_second && have_q && words_disagree(mem_rsp_data, saved_q);
    ev_grant      = ev_rsp_second && !ev_clash && acc_allow;
    at_last       = (idx_q == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      idx_q     <= '0;
      half_q    <= 1'b0;
      base_q    <= '0;
      mw_q      <= '0;
      hs_q      <= 1'b0;
      wr_q      <= 1'b0;
      key_q     <= 1'b0;
      ea_q      <= '0;
      lg_q      <= '0;
      have_q    <= 1'b0;
      saved_q   <= '0;
      good_q    <= '0;
      prot_q    <= '0;
      code_q    <= RC_NONE;
      wb_q      <= '0;
      res_code  <= RC_NONE;
      res_raddr <= '0;
      res_prot  <= '0;
      res_index <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start) begin
            base_q <= grp_base;
            mw_q   <= match_word;
            hs_q   <= hsel;
            wr_q   <= is_write;
            key_q  <= key;
            ea_q   <= eff_addr;
            lg_q   <= page_log2;
            idx_q  <= '0;
            half_q <= 1'b0;
            have_q <= 1'b0;
            code_q <= RC_NONE;
            st_q   <= S_RD_REQ;
          end
        end
        S_RD_REQ: begin
          if (mem_req_ready) st_q <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (ev_rsp_first) begin
            if (cand_hit) begin
              half_q <= 1'b1;
              st_q   <= S_RD_REQ;
            end else if (at_last) begin
              st_q <= S_FIN;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= S_RD_REQ;
            end
          end else if (ev_rsp_second) begin
            half_q <= 1'b0;
            if (ev_clash) begin
              have_q <= 1'b0;
              code_q <= RC_NONE;
              st_q   <= S_FIN;
            end else begin
              have_q  <= 1'b1;
              saved_q <= mem_rsp_data;
              good_q  <= idx_q;
              prot_q  <= acc_prot;
              if (acc_allow) begin
                code_q <= RC_GRANT;
                st_q   <= S_FIN;
              end else begin
                code_q <= RC_DENY;
                if (at_last) begin
                  st_q <= S_FIN;
                end else begin
                  idx_q <= idx_q + 1'b1;
                  st_q  <= S_RD_REQ;
                end
              end
            end
          end
        end
        S_FIN: begin
          if (have_q) begin
            res_code  <= code_q;
            res_raddr <= merged_word | big_page_bits(ea_q, lg_q);
            res_prot  <= prot_q;
            res_index <= good_q;
            wb_q      <= merged_word;
            st_q      <= merged_differs ? S_WB_REQ : S_DONE;
          end else begin
            res_code  <= RC_NONE;
            res_raddr <= '0;
            res_prot  <= '0;
            res_index <= '0;
            st_q      <= S_DONE;
          end
        end
        S_WB_REQ: begin
          if (mem_req_ready) st_q <= S_DONE;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy          = (st_q != S_IDLE);
    done          = (st_q == S_DONE);
    mem_req_valid = (st_q == S_RD_REQ) || (st_q == S_WB_REQ);
    mem_req_write = (st_q == S_WB_REQ);
    mem_req_wdata = wb_q;
    if (st_q == S_WB_REQ)
      mem_req_addr = base_q + AW'({good_q, 3'b100});
    else
      mem_req_addr = base_q + AW'({idx_q, half_q, 2'b00});
  end
endmodule

// File: rtl/pteg_search_chk.sv
module pteg_search_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [1:0]  res_code,
  input logic [1:0]  res_prot,
  input logic        wr_q,
  input logic        ev_clash,
  input logic        ev_grant,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata
);
  a_r10_done_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  a_r8_writeback_has_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[8]);

  a_r4_grant_rights: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_code == 2'b00) |-> (wr_q ? res_prot[1] : res_prot[0]));

  a_r4_grant_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant |-> ##2 (done || (mem_req_valid && mem_req_write)));

  a_r7_clash_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clash |-> ##2 (done && res_code == 2'b10));
endmodule

bind pteg_search pteg_search_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .res_code      (res_code),
  .res_prot      (res_prot),
  .wr_q          (wr_q),
  .ev_clash      (ev_clash),
  .ev_grant      (ev_grant),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata)
);

// File: tb/sim_pteg_search.sv
`timescale 1ns/1ps
module sim_pteg_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] grp_base = '0;
  logic [31:0] match_word = '0;
  logic        hsel = 1'b0;
  logic        is_write = 1'b0;
  logic        key = 1'b0;
  logic [31:0] eff_addr = '0;
  logic [4:0]  page_log2 = 5'd12;
  logic        busy, done;
  logic [1:0]  res_code, res_prot;
  logic [31:0] res_raddr;
  logic [2:0]  res_index;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  pteg_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .grp_base(grp_base),
    .match_word(match_word), .hsel(hsel), .is_write(is_write), .key(key),
    .eff_addr(eff_addr), .page_log2(page_log2), .busy(busy), .done(done),
    .res_code(res_code), .res_raddr(res_raddr), .res_prot(res_prot),
    .res_index(res_index), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [0:1023];

  // Reference model state
  logic [31:0] q_addr[$];
  bit          q_wr[$];
  logic [31:0] q_wd[$];
  logic [1:0]  e_code, e_prot;
  logic [31:0] e_raddr;
  logic [2:0]  e_index;
  string       cur_tag = "R10";
  bit          exp_busy = 1'b0;
  bit          start_pend = 1'b0;
  int          done_cd = -1;
  int          rsp_cnt = 0;
  bit          rsp_last = 1'b0;
  logic [31:0] rsp_hold = '0;
  int          ready_mod = 1;
  int          rsp_lat = 1;
  int          cyc = 0;
  int          ncyc = 0;
  bit          live = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Rights written as conditions rather than a lookup
  function automatic logic [1:0] model_rights(input logic k, input logic [1:0] pp);
    logic rd, wrt;
    if (k == 1'b0) begin
      rd = 1'b1;
      wrt = (pp != 2'd3);
    end else begin
      rd = (pp != 2'd0);
      wrt = (pp == 2'd2);
    end
    return {wrt, rd};
  endfunction

  task automatic predict(input logic [31:0] b, input logic [31:0] mw, input logic hs,
                         input logic wr, input logic k, input logic [31:0] ea, input int lg);
    int good = -1;
    bit granted = 0;
    bit broken = 0;
    logic [31:0] kept = '0;
    logic [31:0] lp = '0;
    logic [1:0]  kept_prot = '0;
    q_addr.delete(); q_wr.delete(); q_wd.delete();
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a0, w0, w1;
      logic [1:0]  rt;
      a0 = b + 32'(i * 8);
      q_addr.push_back(a0); q_wr.push_back(0); q_wd.push_back('0);
      w0 = mem[a0[11:2]];
      if (w0[31] == 1'b1 && w0[6] == hs && {1'b0, w0[30:7], 1'b0, w0[5:0]} == mw) begin
        q_addr.push_back(a0 + 4); q_wr.push_back(0); q_wd.push_back('0);
        w1 = mem[a0[11:2] + 1];
        if (good >= 0 && (w1[31:12] != kept[31:12] || w1[6:3] != kept[6:3] || w1[1:0] != kept[1:0])) begin
          broken = 1;
          break;
        end
        good = i; kept = w1;
        rt = model_rights(k, w1[1:0]);
        kept_prot = rt;
        if ((wr && rt[1]) || (!wr && rt[0])) begin
          granted = 1;
          break;
        end
      end
    end
    if (broken || good < 0) begin
      e_code = 2'b10; e_raddr = '0; e_prot = '0; e_index = '0;
    end else begin
      logic [31:0] nw;
      nw = kept;
      nw[8] = 1'b1;
      if (granted && wr) nw[7] = 1'b1;
      if (nw != kept) begin
        q_addr.push_back(b + 32'(good * 8 + 4)); q_wr.push_back(1); q_wd.push_back(nw);
      end
      for (int bit_i = 12; bit_i < lg && bit_i < 32; bit_i++) lp[bit_i] = ea[bit_i];
      e_code = granted ? 2'b00 : 2'b01;
      e_raddr = nw | lp;
      e_prot = kept_prot;
      e_index = 3'(good);
    end
  endtask

  // Memory model: drives ready and responses just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    mem_rsp_valid = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = rsp_hold;
        if (rsp_last) done_cd = 2;
      end
    end
    mem_req_ready = 1'b0;
    if (mem_req_valid && (cyc % ready_mod) == 0) begin
      mem_req_ready = 1'b1;
      if (q_addr.size() == 0) begin
        chk(1'b0, "R1 unexpected request", mem_req_addr, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] ea_x, ed_x;
        bit ew_x;
        ea_x = q_addr.pop_front(); ew_x = q_wr.pop_front(); ed_x = q_wd.pop_front();
        chk(mem_req_addr == ea_x, "R1 request address", mem_req_addr, ea_x);
        chk(mem_req_write == ew_x, "R8 request direction", {31'b0, mem_req_write}, {31'b0, ew_x});
        if (ew_x) begin
          chk(mem_req_wdata == ed_x, "R8 write data", mem_req_wdata, ed_x);
          mem[mem_req_addr[11:2]] = mem_req_wdata;
          done_cd = 1;
        end else begin
          rsp_hold = mem[mem_req_addr[11:2]];
          rsp_cnt = rsp_lat;
          rsp_last = (q_addr.size() == 0);
        end
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      errors++;
      $display("FAIL R10 watchdog actual=%h expected=%h", ncyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (live) begin
      bit exp_done;
      exp_done = (done_cd == 0);
      chk(busy == exp_busy, "R10 busy", {31'b0, busy}, {31'b0, exp_busy});
      chk(done == exp_done, "R10 done timing", {31'b0, done}, {31'b0, exp_done});
      if (exp_done) begin
        chk(res_code == e_code, {cur_tag, " result code"}, {30'b0, res_code}, {30'b0, e_code});
        chk(res_raddr == e_raddr, {cur_tag, " real address word"}, res_raddr, e_raddr);
        chk(res_prot == e_prot, {cur_tag, " R3 rights"}, {30'b0, res_prot}, {30'b0, e_prot});
        chk(res_index == e_index, {cur_tag, " index"}, {29'b0, res_index}, {29'b0, e_index});
        exp_busy = 1'b0;
      end
      if (done_cd >= 0) done_cd--;
      if (start_pend) begin
        exp_busy = 1'b1;
        start_pend = 1'b0;
      end
    end
  end

  task automatic clear_group(input logic [31:0] b);
    for (int i = 0; i < 16; i++) mem[b[11:2] + 10'(i)] = '0;
  endtask

  task automatic put(input logic [31:0] b, input int i, input logic [31:0] w0, input logic [31:0] w1);
    mem[b[11:2] + 10'(2 * i)] = w0;
    mem[b[11:2] + 10'(2 * i + 1)] = w1;
  endtask

  task automatic run(input string tag, input logic [31:0] b, input logic [31:0] mw, input logic hs,
                     input logic wr, input logic k, input logic [31:0] ea, input int lg,
                     input int rmod, input int lat, input bit disturb);
    cur_tag = tag;
    ready_mod = rmod;
    rsp_lat = lat;
    predict(b, mw, hs, wr, k, ea, lg);
    @(posedge clk); #1;
    grp_base = b; match_word = mw; hsel = hs; is_write = wr; key = k;
    eff_addr = ea; page_log2 = 5'(lg);
    start = 1'b1; start_pend = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (disturb) begin
      repeat (3) @(posedge clk);
      #1;
      // R11: a second start with other inputs while busy
      grp_base = b + 32'h200; is_write = ~wr; key = ~k; match_word = ~mw;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    do begin
      @(negedge clk); #1;
    end while (exp_busy || start_pend);
    chk(q_addr.size() == 0, {tag, " R1 all requests issued"}, 32'(q_addr.size()), 32'd0);
  endtask

  localparam logic [31:0] MW = 32'h0123_4505;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 reset busy", {31'b0, busy}, 32'd0);
    chk(done == 1'b0, "R10 reset done", {31'b0, done}, 32'd0);
    chk(mem_req_valid == 1'b0, "R10 reset request", {31'b0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    live = 1'b1;
    @(negedge clk);

    // R6 / R2: invalid entries and a wrong selector give no match
    clear_group(32'h100);
    put(32'h100, 2, MW, 32'h0005_A002);
    put(32'h100, 5, 32'h8000_0040 | MW, 32'h0005_A002);
    run("R6", 32'h100, MW, 1'b0, 1'b0, 1'b0, '0, 12, 1, 1, 0);

    // R4: key 0, pp 2 read at entry 3, referenced already set, no write
    clear_group(32'h200);
    put(32'h200, 3, 32'h8000_0000 | MW, 32'h0005_A102);
    run("R4", 32'h200, MW, 1'b0, 1'b0, 1'b0, '0, 12, 2, 2, 0);

    // R8: granted write sets both flags and writes back
    clear_group(32'h300);
    put(32'h300, 0, 32'h8000_0000 | MW, 32'h0007_7002);
    run("R8", 32'h300, MW, 1'b0, 1'b1, 1'b1, '0, 12, 1, 3, 0);

    // R3 / R5: key 1, pp 0 read is a violation, referenced written back
    clear_group(32'h400);
    put(32'h400, 2, 32'h8000_0000 | MW, 32'h0001_1000);
    run("R5", 32'h400, MW, 1'b0, 1'b0, 1'b1, '0, 12, 3, 1, 0);

    // R5: two consistent violations, last one reported, no write needed
    clear_group(32'h500);
    put(32'h500, 1, 32'h8000_0000 | MW, 32'h0002_2003);
    put(32'h500, 6, 32'h8000_0000 | MW, 32'h0002_2107);
    run("R5", 32'h500, MW, 1'b0, 1'b1, 1'b0, '0, 12, 1, 1, 0);

    // R7: second match disagrees on frame bits
    clear_group(32'h600);
    put(32'h600, 1, 32'h8000_0000 | MW, 32'h0003_3000);
    put(32'h600, 4, 32'h8000_0000 | MW, 32'h0004_4000);
    put(32'h600, 6, 32'h8000_0000 | MW, 32'h0003_3002);
    run("R7", 32'h600, MW, 1'b0, 1'b0, 1'b1, '0, 12, 2, 1, 0);

    // R2: selector 1, near-miss in bit 0, wrong selector, then a hit at the last entry
    clear_group(32'h700);
    put(32'h700, 0, 32'h8000_0000 | MW, 32'h0009_9002);
    put(32'h700, 3, 32'h8000_0040 | (MW ^ 32'h1), 32'h0009_9002);
    put(32'h700, 7, 32'h8000_0040 | MW, 32'h0008_8000);
    run("R2", 32'h700, MW, 1'b1, 1'b0, 1'b0, '0, 12, 1, 2, 0);

    // R9: 64 KiB page, key 0 pp 3 read granted
    clear_group(32'h800);
    put(32'h800, 4, 32'h8000_0000 | MW, 32'h00AB_0103);
    run("R9", 32'h800, MW, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 16, 1, 1, 0);

    // R3: key 0 pp 3 write is refused
    clear_group(32'h900);
    put(32'h900, 5, 32'h8000_0000 | MW, 32'h00CD_E003);
    run("R3", 32'h900, MW, 1'b0, 1'b1, 1'b0, '0, 12, 1, 1, 0);

    // R11: start pulsed mid-search with different inputs is ignored
    clear_group(32'hA00);
    clear_group(32'hC00);
    put(32'hA00, 6, 32'h8000_0000 | MW, 32'h0006_6001);
    put(32'hC00, 0, 32'h8000_0000 | ~MW, 32'h0001_0002);
    run("R11", 32'hA00, MW, 1'b0, 1'b1, 1'b1, '0, 12, 2, 2, 1);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule